// File: doc/BRIEF.md
# Two-Pass Spectrum Peak Search Controller

This block finds the direction with the largest spatial-spectrum value. It does not compute the spectrum. It sends angle indices one at a time to an external spectrum evaluator and keeps the largest value that comes back. Angles are counted in tenths of a degree, so 0 to 180° is the index range 0 to 1800.

Every search starts with a coarse sweep. This sweep steps by 1° across the whole range, and its winner goes into a result store. In coarse mode that stored winner is the answer. In fine mode a second sweep follows. It steps by 0.1° through a window of ±1.0° around the stored winner, clipped to the range, and its best point is the answer.

Each request goes out as a single-cycle pulse. The controller then waits, for any number of cycles, until the evaluator returns a value. When the search ends, the controller pulses a done signal and holds the winning angle and its value.

Top module: `peak_search_ctrl`

## Requirements
- R1: While reset is high, and right after it, `req_valid` and `done` are 0 and `peak_angle` and `peak_value` are 0. A reset in the middle of a search returns the block to this state.
- R2: Every search first requests angles 0, 10, 20, …, 1800 in rising order, which is 181 requests. No request angle exceeds 1800.
- R3: `req_valid` is high for one cycle per request. Only one request is outstanding at a time. A `rsp_valid` that arrives while no request is pending is ignored and changes neither the requests nor the result.
- R4: With `fine_mode` low at start, no further requests follow the coarse sweep. The result is the coarse angle with the largest returned value, together with that value.
- R5: With `fine_mode` high at start, the coarse sweep is followed by requests at every index from max(0, W−10) to min(1800, W+10) in rising order, where W is the coarse winner.
- R6: In fine mode the result is the angle in the fine window with the largest returned value, together with that value.
- R7: When several angles in a sweep return the same largest value, the smallest of those angles wins.
- R8: `done` is a one-cycle pulse. `peak_angle` and `peak_value` change only in the cycle in which `done` is high.
- R9: A `start` pulse during a search is ignored. `fine_mode` is sampled only when a search starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a search when the block is idle |
| fine_mode | input | 1 | 1 = 0.1° refinement, 0 = 1° result only; sampled at start |
| req_valid | output | 1 | One-cycle request pulse to the evaluator |
| req_angle | output | AW (11) | Requested angle in tenths of a degree |
| rsp_valid | input | 1 | Evaluator returns a value for the pending request |
| rsp_value | input | VW (16) | Spectrum value, unsigned |
| done | output | 1 | One-cycle pulse when the result is ready |
| peak_angle | output | AW (11) | Winning angle in tenths of a degree |
| peak_value | output | VW (16) | Spectrum value at the winning angle |

## Verification
The bench builds the block with its default parameters: an 1800-index range, a coarse step of 10, a fine step of 1 and a fine half-width of 10. With these values the fine window gets clipped at both ends of the range, which happens when the coarse winner is 0 or 1800, and the window then shrinks to 11 points.

The bench's evaluator model returns a triangular spectrum with an optional flat top. It answers after a latency chosen per test. This makes it possible to set up coarse ties, where two neighbouring 1° points are equally far from the peak, and fine ties on a plateau, which exercises the smallest-angle rule in both sweeps.

// File: rtl/peak_search_pkg.sv
package peak_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for start
    ST_WAIT,   // request issued, waiting for the evaluator
    ST_STORE,  // coarse sweep finished, latch winner
    ST_FIN     // publish result
  } srch_state_t;

endpackage

// File: rtl/pk_window.sv
// Fine-window bounds around a centre angle, clamped to [0, SPAN].
module pk_window #(
  parameter int AW   = 11,
  parameter int SPAN = 1800,
  parameter int HALF = 10
) (
  input  logic [AW-1:0] center,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi
);
  localparam logic [AW:0] HALF_W = (AW+1)'(HALF);
  localparam logic [AW:0] SPAN_W = (AW+1)'(SPAN);

  logic [AW:0] c_w, sum_w;

  always_comb begin
    c_w   = {1'b0, center};
    sum_w = c_w + HALF_W;
    lo    = (c_w < HALF_W) ? '0 : AW'(c_w - HALF_W);
    hi    = (sum_w > SPAN_W) ? AW'(SPAN_W) : AW'(sum_w);
  end
endmodule

// File: rtl/pk_tracker.sv
// Running maximum; strictly-greater update keeps the earliest angle on ties.
module pk_tracker #(
  parameter int AW = 11,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic [AW-1:0] angle,
  input  logic [VW-1:0] value,
  output logic [AW-1:0] best_angle,
  output logic [VW-1:0] best_value
);
  logic have;

  always_ff @(posedge clk) begin
    if (rst) begin
      have       <= 1'b0;
      best_angle <= '0;
      best_value <= '0;
    end else if (clr) begin
      have <= 1'b0;
    end else if (upd) begin
      have <= 1'b1;
      if (!have || value > best_value) begin
        best_angle <= angle;
        best_value <= value;
      end
    end
  end
endmodule

// File: rtl/pk_store.sv
// Result store holding the coarse-sweep winner.
module pk_store #(
  parameter int AW = 11,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] d_angle,
  input  logic [VW-1:0] d_value,
  output logic [AW-1:0] q_angle,
  output logic [VW-1:0] q_value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_angle <= '0;
      q_value <= '0;
    end else if (we) begin
      q_angle <= d_angle;
      q_value <= d_value;
    end
  end
endmodule

// File: rtl/peak_search_ctrl.sv
module peak_search_ctrl #(
  parameter int AW          = 11,
  parameter int VW          = 16,
  parameter int SPAN        = 1800,
  parameter int COARSE_STEP = 10,
  parameter int FINE_STEP   = 1,
  parameter int FINE_HALF   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fine_mode,
  output logic          req_valid,
  output logic [AW-1:0] req_angle,
  input  logic          rsp_valid,
  input  logic [VW-1:0] rsp_value,
  output logic          done,
  output logic [AW-1:0] peak_angle,
  output logic [VW-1:0] peak_value
);
  import peak_search_pkg::*;

  localparam logic [AW-1:0] COARSE_LAST = AW'((SPAN / COARSE_STEP) * COARSE_STEP);
  localparam logic [AW-1:0] C_STEP      = AW'(COARSE_STEP);
  localparam logic [AW-1:0] F_STEP      = AW'(FINE_STEP);

  srch_state_t   state;
  logic          fine_q;     // mode latched at start
  logic          in_fine;    // second sweep active
  logic [AW-1:0] step_q;
  logic [AW-1:0] end_q;

  logic          accept, trk_clr, store_we;
  logic [AW-1:0] best_a, cache_a, win_lo, win_hi;
  logic [VW-1:0] best_v, cache_v;

  assign accept   = (state == ST_WAIT) && rsp_valid && !req_valid;
  assign trk_clr  = ((state == ST_IDLE) && start) || ((state == ST_STORE) && fine_q);
  assign store_we = (state == ST_STORE);

  pk_tracker #(.AW(AW), .VW(VW)) u_trk (
    .clk(clk), .rst(rst), .clr(trk_clr), .upd(accept),
    .angle(req_angle), .value(rsp_value),
    .best_angle(best_a), .best_value(best_v)
  );

  pk_store #(.AW(AW), .VW(VW)) u_store (
    .clk(clk), .rst(rst), .we(store_we),
    .d_angle(best_a), .d_value(best_v),
    .q_angle(cache_a), .q_value(cache_v)
  );

  pk_window #(.AW(AW), .SPAN(SPAN), .HALF(FINE_HALF)) u_win (
    .center(best_a), .lo(win_lo), .hi(win_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_valid  <= 1'b0;
      req_angle  <= '0;
      done       <= 1'b0;
      peak_angle <= '0;
      peak_value <= '0;
      fine_q     <= 1'b0;
      in_fine    <= 1'b0;
      step_q     <= '0;
      end_q      <= '0;
    end else begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            fine_q    <= fine_mode;
            in_fine   <= 1'b0;
            req_angle <= '0;
            step_q    <= C_STEP;
            end_q     <= COARSE_LAST;
            req_valid <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (accept) begin
            if (req_angle == end_q) begin
              state <= in_fine ? ST_FIN : ST_STORE;
            end else begin
              req_angle <= req_angle + step_q;
              req_valid <= 1'b1;
            end
          end
        end
        ST_STORE: begin
          if (fine_q) begin
            in_fine   <= 1'b1;
            req_angle <= win_lo;
            end_q     <= win_hi;
            step_q    <= F_STEP;
            req_valid <= 1'b1;
            state     <= ST_WAIT;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_FIN: begin
          done       <= 1'b1;
          peak_angle <= in_fine ? best_a : cache_a;
          peak_value <= in_fine ? best_v : cache_v;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/peak_search_chk.sv
module peak_search_chk #(
  parameter int AW   = 11,
  parameter int VW   = 16,
  parameter int SPAN = 1800
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_angle,
  input logic          rsp_valid,
  input logic          done,
  input logic [AW-1:0] peak_angle,
  input logic [VW-1:0] peak_value
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst)            pend <= 1'b0;
    else if (req_valid) pend <= 1'b1;
    else if (rsp_valid) pend <= 1'b0;
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !pend);

  // R2
  angle_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_angle <= AW'(SPAN)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  peak_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(peak_angle) && $stable(peak_value)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pend && !req_valid));
endmodule

bind peak_search_ctrl peak_search_chk #(.AW(AW), .VW(VW), .SPAN(SPAN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_angle(req_angle),
  .rsp_valid(rsp_valid), .done(done), .peak_angle(peak_angle),
  .peak_value(peak_value)
);

// File: tb/sim_peak_search_ctrl.sv
`timescale 1ns/1ps
module sim_peak_search_ctrl;
  localparam int AW = 11;
  localparam int VW = 16;
  localparam int H  = 5000;

  typedef struct packed {
    int fine; int center; int plat; int lat;
    int exp_a; int exp_v; int exp_n; int tie;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{0,  453, 0, 1,  450, 4997, 181, 0},
    '{1,  453, 0, 2,  453, 5000, 202, 0},
    '{1,    0, 0, 1,    0, 5000, 192, 0},
    '{1, 1800, 0, 3, 1800, 5000, 192, 0},
    '{1, 1797, 0, 1, 1797, 5000, 192, 0},
    '{0,  455, 0, 2,  450, 4995, 181, 1},
    '{1,  455, 3, 1,  452, 5000, 202, 1},
    '{1, 1234, 0, 4, 1234, 5000, 202, 0},
    '{0, 1797, 0, 1, 1800, 4997, 181, 0},
    '{1,    5, 0, 2,    5, 5000, 192, 1}
  };

  logic clk = 1'b0;
  logic rst, start, fine_mode;
  logic req_valid, done;
  logic [AW-1:0] req_angle, peak_angle;
  logic [VW-1:0] rsp_value, peak_value, ev_value;
  logic ev_valid, stray_valid, rsp_valid;

  assign rsp_valid = ev_valid | stray_valid;

  always #5 clk = ~clk;

  peak_search_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .fine_mode(fine_mode),
    .req_valid(req_valid), .req_angle(req_angle),
    .rsp_valid(rsp_valid), .rsp_value(rsp_value),
    .done(done), .peak_angle(peak_angle), .peak_value(peak_value)
  );
  assign rsp_value = ev_value;

  int compared = 0, mismatched = 0;
  int cur_p, cur_w, cur_lat;
  int nreq, overlap;
  int rlog [256];

  function automatic int spec(input int a, input int p, input int w);
    int d;
    d = (a > p) ? a - p : p - a;
    return (d <= w) ? H : H - (d - w);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // evaluator model
  initial begin
    ev_valid = 1'b0;
    ev_value = '0;
    @(negedge clk);
    forever begin
      if (req_valid === 1'b1) begin
        int a;
        a = int'(req_angle);
        if (nreq < 256) rlog[nreq] = a;
        nreq++;
        repeat (cur_lat) @(negedge clk) begin
          if (req_valid === 1'b1) overlap++;
        end
        ev_valid = 1'b1;
        ev_value = VW'(spec(a, cur_p, cur_w));
        @(negedge clk);
        ev_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // global watchdog
  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary_and_end();
  end

  task automatic run_search(input int fine, input int p, input int w, input int lat,
                            input bit inject, input int exp_a, input int exp_v,
                            input int exp_n, input string rtag);
    int cyc;
    int ca, cv, lo, hi, k;
    bit ok;
    cur_p = p; cur_w = w; cur_lat = lat;
    nreq = 0; overlap = 0;
    @(negedge clk);
    start = 1'b1; fine_mode = fine[0];
    @(negedge clk);
    start = 1'b0; fine_mode = ~fine[0];   // R9: later mode changes must not matter
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      if (inject && cyc == 60) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc < 20000, "R8 done seen", cyc, 0);
    chk(int'(peak_angle) == exp_a, {rtag, " angle"}, int'(peak_angle), exp_a);
    chk(int'(peak_value) == exp_v, {rtag, " value"}, int'(peak_value), exp_v);
    chk(nreq == exp_n, fine ? "R5 request count" : "R4 request count", nreq, exp_n);
    chk(overlap == 0, "R3 outstanding", overlap, 0);
    // independent request-order model
    ok = 1'b1; ca = 0; cv = -1;
    for (int i = 0; i <= 180; i++) begin
      if (rlog[i] != i * 10) ok = 1'b0;
      if (spec(i * 10, p, w) > cv) begin cv = spec(i * 10, p, w); ca = i * 10; end
    end
    chk(ok, "R2 coarse order", rlog[0], 0);
    if (fine) begin
      lo = (ca < 10) ? 0 : ca - 10;
      hi = (ca + 10 > 1800) ? 1800 : ca + 10;
      ok = 1'b1; k = 181;
      for (int a = lo; a <= hi; a++) begin
        if (k >= 256 || rlog[k] != a) ok = 1'b0;
        k++;
      end
      chk(ok, "R5 fine window order", rlog[181], lo);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done pulse", int'(done), 0);
  endtask

  initial begin
    int hold_a, hold_v;
    rst = 1'b1; start = 1'b0; fine_mode = 1'b0; stray_valid = 1'b0;
    cur_p = 0; cur_w = 0; cur_lat = 1; nreq = 0; overlap = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(peak_angle == '0, "R1 peak_angle", int'(peak_angle), 0);
    chk(peak_value == '0, "R1 peak_value", int'(peak_value), 0);

    // R3: stray response while idle is ignored
    stray_valid = 1'b1;
    @(negedge clk);
    stray_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0 && done == 1'b0, "R3 stray idle", int'(req_valid), 0);
    chk(peak_value == '0, "R3 stray result", int'(peak_value), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      string tg;
      if (VECS[v].tie != 0) tg = "R7";
      else if (VECS[v].fine != 0) tg = "R6";
      else tg = "R4";
      run_search(VECS[v].fine, VECS[v].center, VECS[v].plat, VECS[v].lat, 1'b0,
                 VECS[v].exp_a, VECS[v].exp_v, VECS[v].exp_n, tg);
    end

    // R8: result held while idle
    hold_a = int'(peak_angle); hold_v = int'(peak_value);
    repeat (20) @(negedge clk);
    chk(int'(peak_angle) == hold_a && int'(peak_value) == hold_v,
        "R8 hold", int'(peak_angle), hold_a);

    // R9: start during a fine search is ignored
    run_search(1, 777, 0, 2, 1'b1, 777, 5000, 202, "R9");

    // R1: reset in the middle of a search
    cur_p = 900; cur_w = 0; cur_lat = 1; nreq = 0;
    @(negedge clk);
    start = 1'b1; fine_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0 && done == 1'b0, "R1 mid-run reset ctl", int'(req_valid), 0);
    chk(peak_angle == '0 && peak_value == '0, "R1 mid-run reset peak", int'(peak_angle), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    run_search(0, 900, 0, 1, 1'b0, 900, 5000, 181, "R4");

    summary_and_end();
  end
endmodule